// File: doc/BRIEF.md
# Core Reset and NMI History Recorder

This block keeps a sticky record of reset and non-maskable interrupt activity for a multicore device with up to eight cores. It watches a device-wide reset event, one local reset event per core and one NMI event per core, and turns each rising edge into a flag that stays set until software clears it. Two status words are kept. The reset history word holds one device-wide flag and one flag per core. The event capture word holds one local-reset flag and one NMI flag per core, but only for the cores chosen by a core-select vector.

Software reaches the flags over a simple word bus with four locations. The two status locations are read-only. Two clear locations each take a write-one-to-clear mask, and a read of a clear location returns the status word it controls. When an event and a clear hit the same bit in the same cycle, the event wins. A device-wide reset event sets the device flag and clears every per-core reset flag, so software can tell a full-device restart from a restart of a single core.

Top module: `rst_nmi_history`

## Requirements
- R1: When `rst_n` is low at a clock edge, the reset history word becomes 0x8000_0000 and the event capture word becomes 0.
- R2: Reset history word (word index 2, byte offset 0x8): bit 31 holds the device-wide reset flag, bit i (i < 8) holds the local-reset flag of core i, and bits 30..8 read as 0.
- R3: A device-wide reset event sets bit 31 and clears bits 7..0 of the reset history word at the same edge. This holds even when local reset events arrive in that cycle.
- R4: A local reset event on core i sets bit i of the reset history word and leaves bit 31 unchanged.
- R5: Event capture word (word index 0, byte offset 0x0): a local reset event on core i sets bit i and an NMI event on core i sets bit 16+i, but only while `core_sel[i]` is 1. Every other bit reads 0.
- R6: Every flag stays set after its event input goes low, until a clear removes it.
- R7: Events are detected on the rising edge. An input held high sets its flag once, and a flag cleared while the input is still high stays clear.
- R8: Writing a mask to byte offset 0xC clears each reset history bit (31 and 7..0) whose mask bit is 1. Mask bits that are 0 leave their flags unchanged.
- R9: Writing a mask to byte offset 0x4 clears each event capture bit (23..16 and 7..0) whose mask bit is 1. Mask bits that are 0 and reserved mask bits have no effect.
- R10: When an event and a clear target the same bit in the same cycle, the bit ends up set.
- R11: A read of 0x4 or 0xC returns the current event capture word or reset history word. A write to 0x0 or 0x8 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_rst_evt | input | 1 | Device-wide reset event (rising edge detected) |
| core_rst_evt | input | NUM_CORES | Per-core local reset events |
| core_nmi_evt | input | NUM_CORES | Per-core NMI events |
| core_sel | input | NUM_CORES | Selects which cores feed the event capture word |
| bus_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 4 | Byte address; bits 3..2 pick the word |
| bus_wdata | input | 32 | Write data / clear mask |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |

## Verification
The embedded assertions check the cycle-level rules on every cycle:
- a set beats a clear on the same bit;
- a cleared bit drops at the next edge;
- flags hold when nothing clears them;
- a device-wide event leaves the device flag set and every per-core reset flag clear;
- reserved bits of the reset history word read as zero;
- an edge pulse never lasts two cycles.

The bench scenarios are needed to show the rest:
- the mapping of bits to bus locations;
- the reset values;
- the gating by core select;
- that zero mask bits and writes to status locations have no effect;
- that a held input is not captured again after a clear.

// File: rtl/rsth_pkg.sv
// Package: shared bus map and field positions for the reset/NMI history block.
// Assumes a 32-bit data word and word-aligned addressing (byte address bits 3..2).
package rsth_pkg;
    localparam int DATA_W      = 32;
    localparam int MAX_CORES   = 8;
    localparam int DEV_BIT     = 31;
    localparam int NMI_LSB     = 16;
    localparam logic [1:0] IDX_CAP     = 2'd0;
    localparam logic [1:0] IDX_CAP_CLR = 2'd1;
    localparam logic [1:0] IDX_HIST    = 2'd2;
    localparam logic [1:0] IDX_HIST_CLR= 2'd3;
endpackage

// File: rtl/rsth_edge.sv
// Module: rsth_edge
// Turns level event inputs into single-cycle pulses on their rising edge.
// Assumes inputs are synchronous to clk; the history register resets to 0, so an
// input already high when reset ends produces one pulse.
module rsth_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] pulse_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // Pulse only on a low-to-high transition.
    always_comb pulse_o = lvl_i & ~prev_q;

    // A held input must not produce back-to-back pulses.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pulse_o & $past(pulse_o)) == '0));
endmodule

// File: rtl/rsth_sticky.sv
// Module: rsth_sticky
// Bank of sticky flags. Priority per bit: kill (force 0) over set over clear.
// Assumes set/clr/kill are single-cycle strobes from the same clock domain.
module rsth_sticky #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] kill_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    // Update flags: clear first, then set, then kill overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= RST_VAL;
        else        flags_q <= ((flags_q & ~clr_i) | set_i) & ~kill_i;
    end

    assign flags_o = flags_q;

    // An event beats a clear on the same bit.
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~kill_i)) |=>
        ((flags_o & $past(set_i & ~kill_i)) == $past(set_i & ~kill_i)));

    // Clear-only bits drop at the next edge (serves R8 and R9).
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    // Flags hold without a clear or kill.
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags_o) & ~$past(clr_i) & ~$past(kill_i) & ~flags_o) == '0));

    // A kill forces its bits to zero.
    assert_kill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|kill_i) |=> ((flags_o & $past(kill_i)) == '0));
endmodule

// File: rtl/rsth_regif.sv
// Module: rsth_regif
// Bus decode: builds clear strobes from write masks and muxes the read word.
// Assumes word-aligned access; byte address bits 1..0 are ignored.
module rsth_regif
    import rsth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              wr_en_i,
    input  logic [3:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] cap_word_i,
    input  logic [DATA_W-1:0] hist_word_i,
    output logic              clr_dev_o,
    output logic [N-1:0]      clr_hist_lr_o,
    output logic [N-1:0]      clr_cap_lr_o,
    output logic [N-1:0]      clr_cap_nmi_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [1:0] idx;
    logic       hit_cap_clr;
    logic       hit_hist_clr;
    logic       unused_bits;

    assign idx          = addr_i[3:2];
    assign hit_cap_clr  = wr_en_i && (idx == IDX_CAP_CLR);
    assign hit_hist_clr = wr_en_i && (idx == IDX_HIST_CLR);
    assign unused_bits  = ^{addr_i[1:0], wdata_i};

    // Derive per-field clear strobes from the written mask.
    always_comb begin
        clr_dev_o     = hit_hist_clr & wdata_i[DEV_BIT];
        clr_hist_lr_o = hit_hist_clr ? wdata_i[N-1:0] : '0;
        clr_cap_lr_o  = hit_cap_clr  ? wdata_i[N-1:0] : '0;
        clr_cap_nmi_o = hit_cap_clr  ? wdata_i[NMI_LSB +: N] : '0;
    end

    // Read mux: clear locations mirror their status word.
    always_comb begin
        unique case (idx)
            IDX_CAP, IDX_CAP_CLR: rdata_o = cap_word_i;
            default:              rdata_o = hist_word_i;
        endcase
    end
endmodule

// File: rtl/rst_nmi_history.sv
// Module: rst_nmi_history
// Top: sticky reset/NMI history for up to eight cores plus a device-wide flag.
// Assumes event inputs are synchronous to clk; NUM_CORES must not exceed 8.
module rst_nmi_history
    import rsth_pkg::*;
#(
    parameter int NUM_CORES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dev_rst_evt,
    input  logic [NUM_CORES-1:0] core_rst_evt,
    input  logic [NUM_CORES-1:0] core_nmi_evt,
    input  logic [NUM_CORES-1:0] core_sel,
    input  logic                 bus_wr_en,
    input  logic [3:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata
);
    localparam int EVT_W = 1 + 2 * NUM_CORES;

    logic [EVT_W-1:0]     evt_pulse;
    logic                 dev_pulse;
    logic [NUM_CORES-1:0] rst_pulse, nmi_pulse;
    logic                 dev_flag;
    logic [NUM_CORES-1:0] hist_lr, cap_lr, cap_nmi;
    logic                 clr_dev;
    logic [NUM_CORES-1:0] clr_hist_lr, clr_cap_lr, clr_cap_nmi;
    logic [DATA_W-1:0]    cap_word, hist_word;

    rsth_edge #(.W(EVT_W)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl_i({dev_rst_evt, nmi_evt_w(core_nmi_evt), core_rst_evt}),
        .pulse_o(evt_pulse)
    );

    function automatic logic [NUM_CORES-1:0] nmi_evt_w(input logic [NUM_CORES-1:0] v);
        return v;
    endfunction

    assign rst_pulse = evt_pulse[NUM_CORES-1:0];
    assign nmi_pulse = evt_pulse[2*NUM_CORES-1:NUM_CORES];
    assign dev_pulse = evt_pulse[EVT_W-1];

    rsth_sticky #(.W(1), .RST_VAL(1'b1)) u_dev (
        .clk(clk), .rst_n(rst_n), .set_i(dev_pulse), .clr_i(clr_dev),
        .kill_i(1'b0), .flags_o(dev_flag)
    );

    rsth_sticky #(.W(NUM_CORES)) u_hist_lr (
        .clk(clk), .rst_n(rst_n), .set_i(rst_pulse), .clr_i(clr_hist_lr),
        .kill_i({NUM_CORES{dev_pulse}}), .flags_o(hist_lr)
    );

    rsth_sticky #(.W(NUM_CORES)) u_cap_lr (
        .clk(clk), .rst_n(rst_n), .set_i(rst_pulse & core_sel), .clr_i(clr_cap_lr),
        .kill_i('0), .flags_o(cap_lr)
    );

    rsth_sticky #(.W(NUM_CORES)) u_cap_nmi (
        .clk(clk), .rst_n(rst_n), .set_i(nmi_pulse & core_sel), .clr_i(clr_cap_nmi),
        .kill_i('0), .flags_o(cap_nmi)
    );

    // Assemble the two status words; unlisted bits stay zero.
    always_comb begin
        cap_word                     = '0;
        cap_word[0 +: NUM_CORES]     = cap_lr;
        cap_word[NMI_LSB +: NUM_CORES] = cap_nmi;
        hist_word                    = '0;
        hist_word[0 +: NUM_CORES]    = hist_lr;
        hist_word[DEV_BIT]           = dev_flag;
    end

    rsth_regif #(.N(NUM_CORES)) u_regif (
        .wr_en_i(bus_wr_en), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .cap_word_i(cap_word), .hist_word_i(hist_word),
        .clr_dev_o(clr_dev), .clr_hist_lr_o(clr_hist_lr),
        .clr_cap_lr_o(clr_cap_lr), .clr_cap_nmi_o(clr_cap_nmi),
        .rdata_o(bus_rdata)
    );

    // Device-wide event leaves only the device flag set in the history word.
    assert_dev_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pulse |=> (dev_flag && (hist_lr == '0)));

    // Reserved bits of the history word read as zero.
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:2] == IDX_HIST) |-> (bus_rdata[DEV_BIT-1:NUM_CORES] == '0));
endmodule

// File: tb/sim_rst_nmi_history.sv
module sim_rst_nmi_history;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_rst_evt = 1'b0;
    logic [7:0]  core_rst_evt = '0, core_nmi_evt = '0, core_sel = '0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  drv_addr = '0, mon_addr = '0, bus_addr;
    logic        mon_active = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [3:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;
    assign bus_addr = mon_active ? mon_addr : drv_addr;

    rst_nmi_history #(.NUM_CORES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_rst_evt(dev_rst_evt),
        .core_rst_evt(core_rst_evt), .core_nmi_evt(core_nmi_evt),
        .core_sel(core_sel), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Monitor: pops expected reads and compares them against the bus.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            mon_addr   = sb_q[0].addr;
            mon_active = 1'b1;
            #1;
            checks++;
            if (bus_rdata !== sb_q[0].exp) begin
                errors++;
                $display("FAIL %s addr=0x%0h actual=0x%08h expected=0x%08h",
                         sb_q[0].tag, sb_q[0].addr, bus_rdata, sb_q[0].exp);
            end
            mon_active = 1'b0;
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        drv_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic pulse_core(input logic [7:0] rst_v, input logic [7:0] nmi_v);
        @(negedge clk);
        core_rst_evt = rst_v; core_nmi_evt = nmi_v;
        @(negedge clk);
        core_rst_evt = '0; core_nmi_evt = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, R2 layout, R11 mirror reads
        expect_rd(4'h8, 32'h8000_0000, "R1");
        expect_rd(4'h0, 32'h0000_0000, "R1");
        expect_rd(4'hC, 32'h8000_0000, "R11");
        expect_rd(4'h4, 32'h0000_0000, "R11");
        // R11 write to status location ignored; R8 zero mask no effect
        bus_write(4'h8, 32'hFFFF_FFFF);
        expect_rd(4'h8, 32'h8000_0000, "R11");
        bus_write(4'hC, 32'h0000_0000);
        expect_rd(4'h8, 32'h8000_0000, "R8");
        bus_write(4'hC, 32'h8000_0000);
        expect_rd(4'h8, 32'h0000_0000, "R8");
        // R4 local resets cores 1,5; R5 only core 1 selected
        core_sel = 8'h02;
        pulse_core(8'h22, 8'h00);
        expect_rd(4'h8, 32'h0000_0022, "R4");
        expect_rd(4'h0, 32'h0000_0002, "R5");
        // R5 NMI cores 0,3,6 with cores 3,6 selected; R6 flags held
        core_sel = 8'h48;
        pulse_core(8'h00, 8'h49);
        expect_rd(4'h0, 32'h0048_0002, "R5");
        expect_rd(4'h8, 32'h0000_0022, "R6");
        // R9 reserved mask bits no effect, then partial clear
        bus_write(4'h4, 32'hFF00_FF00);
        expect_rd(4'h0, 32'h0048_0002, "R9");
        bus_write(4'h0, 32'hFFFF_FFFF);
        expect_rd(4'h0, 32'h0048_0002, "R11");
        bus_write(4'h4, 32'h0008_0002);
        expect_rd(4'h4, 32'h0040_0000, "R9");
        // R7 held input captured once, stays clear after clear
        core_sel = 8'h04;
        @(negedge clk);
        core_rst_evt = 8'h04;
        repeat (2) @(negedge clk);
        expect_rd(4'h8, 32'h0000_0026, "R7");
        bus_write(4'hC, 32'h0000_0004);
        repeat (2) @(negedge clk);
        expect_rd(4'h8, 32'h0000_0022, "R7");
        expect_rd(4'h0, 32'h0040_0004, "R7");
        @(negedge clk);
        core_rst_evt = 8'h00;
        // R10 event and clear on core 7 in the same cycle
        @(negedge clk);
        core_rst_evt = 8'h80; drv_addr = 4'hC; bus_wdata = 32'h0000_0080; bus_wr_en = 1'b1;
        @(negedge clk);
        core_rst_evt = 8'h00; bus_wr_en = 1'b0;
        expect_rd(4'h8, 32'h0000_00A2, "R10");
        // R3 device event with a simultaneous local event
        core_sel = 8'h00;
        @(negedge clk);
        dev_rst_evt = 1'b1; core_rst_evt = 8'h10;
        @(negedge clk);
        dev_rst_evt = 1'b0; core_rst_evt = 8'h00;
        expect_rd(4'h8, 32'h8000_0000, "R3");
        // R10 device event and device-flag clear together
        bus_write(4'hC, 32'h8000_0000);
        expect_rd(4'h8, 32'h0000_0000, "R8");
        @(negedge clk);
        dev_rst_evt = 1'b1; drv_addr = 4'hC; bus_wdata = 32'h8000_0000; bus_wr_en = 1'b1;
        @(negedge clk);
        dev_rst_evt = 1'b0; bus_wr_en = 1'b0;
        expect_rd(4'h8, 32'h8000_0000, "R10");
        // R1 reset reapplied mid-run
        core_sel = 8'hFF;
        pulse_core(8'h0F, 8'hF0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_rd(4'h8, 32'h8000_0000, "R1");
        expect_rd(4'h0, 32'h0000_0000, "R1");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule